// File: doc/BRIEF.md
# Dual-Port Keyboard and Pointer Controller

This block models, at the register level, a host-facing controller for two serial input devices: a keyboard port and an auxiliary pointer port. The host sees two byte-wide locations. The data location is at offset 0. A shared location at offset 4 takes command bytes on write and returns a status byte on read. An output buffer holds one byte for the host and records which port it came from. An input stage holds the last byte the host wrote for one cycle while the controller acts on it.

The controller runs a fixed set of commands. Some commands return a result byte through the output buffer. Others arm a parameter phase in which the next data byte is consumed: it can be written to the 8-bit control register, sent to the pointer device, or echoed back as if a device had produced it. The control register enables one interrupt per port and disables each port's input. Device bytes arrive on simple valid/data strobes. Bytes for the devices leave on one-cycle valid/data strobes. The serial wire protocol is handled elsewhere.

Top module: `kbc_dual_port`

## Requirements
- R1: After reset the status byte reads 0x10 while `lock_open` is 1, the control register reads back as 0x00, and both interrupt outputs and both forward strobes are low.
- R2: A host write to offset 0 or 4 is accepted only while input-full (status bit 1, 0x02) is clear. Input-full reads 1 for exactly the one cycle after acceptance. A write presented while it is set is ignored.
- R3: Status bit 3 (0x08) is set by an accepted write to offset 4 and cleared by an accepted write to offset 0.
- R4: Reading offset 0 returns the output buffer byte and clears output-full (status bit 0, 0x01). Reading offset 4 returns status and clears nothing.
- R5: Command 0x20 places the control register in the output buffer. Command 0x60 makes the next data byte the new control register value.
- R6: Command 0xAA returns 0x55. Commands 0xAB and 0xA9 each return 0x00. Any controller result loads the output buffer even when it is already full.
- R7: Commands 0xA7 and 0xA8 set and clear control bit 5 (pointer port off). Commands 0xAD and 0xAE set and clear control bit 4 (keyboard port off). A later 0x20 shows the change.
- R8: After 0xD2 the next data byte enters the output buffer tagged as keyboard. After 0xD3 it is tagged as pointer, which shows as status bit 5 (0x20).
- R9: After 0xD4 the next data byte leaves on `aux_out_valid`/`aux_out_data`. A data byte with no armed phase leaves on `kbd_out_valid`/`kbd_out_data`. Each strobe is a one-cycle pulse, and the two never fire together.
- R10: A device byte is loaded only when output-full is clear and its port is not off. The keyboard wins when both ports present a byte in the same cycle. A byte that is not loaded is dropped.
- R11: `kbd_irq` is high while output-full is set with a keyboard-tagged byte and control bit 0 is set. `aux_irq` is high while output-full is set with a pointer-tagged byte and control bit 1 is set.
- R12: An unrecognised command byte leaves the control register and output buffer unchanged.
- R13: Status bit 4 (0x10) is `lock_open` OR control bit 3. Status bits 2, 6 and 7 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | ADDR_W | Host byte offset: 0 for data, 4 for command/status |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Status byte at offset 4, otherwise the output buffer |
| lock_open | input | 1 | Keylock switch is in the unlocked position |
| kbd_in_valid | input | 1 | Keyboard device byte valid |
| kbd_in_data | input | 8 | Keyboard device byte |
| aux_in_valid | input | 1 | Pointer device byte valid |
| aux_in_data | input | 8 | Pointer device byte |
| kbd_out_valid | output | 1 | One-cycle strobe: byte for the keyboard |
| kbd_out_data | output | 8 | Byte for the keyboard |
| aux_out_valid | output | 1 | One-cycle strobe: byte for the pointer |
| aux_out_data | output | 8 | Byte for the pointer |
| kbd_irq | output | 1 | Keyboard byte waiting and its interrupt enabled |
| aux_irq | output | 1 | Pointer byte waiting and its interrupt enabled |

## Verification
A wrong pending parameter phase only shows up one host write later. The data byte then lands in the wrong place: the control register, a forward strobe, or the output buffer with the wrong port tag. The bench therefore follows every armed command with its data byte and checks the result two cycles after that byte is written. A corrupt control register shows at once on the interrupt outputs and on whether device bytes are admitted, and on the next 0x20 readback. A stuck output-full flag shows the next time a device byte is presented: either a held byte is replaced, or a byte is dropped that should have been loaded.

// File: rtl/kbc_pkg.sv
// Shared constants and types for the dual-port keyboard/pointer controller.
// Assumes byte-wide host and device paths.
package kbc_pkg;
    localparam int BYTE_W = 8;
    typedef logic [BYTE_W-1:0] kbyte_t;

    localparam kbyte_t OP_RD_CTRL   = 8'h20;
    localparam kbyte_t OP_WR_CTRL   = 8'h60;
    localparam kbyte_t OP_SELFTEST  = 8'hAA;
    localparam kbyte_t OP_KBD_TEST  = 8'hAB;
    localparam kbyte_t OP_AUX_TEST  = 8'hA9;
    localparam kbyte_t OP_AUX_OFF   = 8'hA7;
    localparam kbyte_t OP_AUX_ON    = 8'hA8;
    localparam kbyte_t OP_KBD_OFF   = 8'hAD;
    localparam kbyte_t OP_KBD_ON    = 8'hAE;
    localparam kbyte_t OP_KBD_ECHO  = 8'hD2;
    localparam kbyte_t OP_AUX_ECHO  = 8'hD3;
    localparam kbyte_t OP_AUX_SEND  = 8'hD4;

    localparam kbyte_t SELFTEST_OK  = 8'h55;
    localparam kbyte_t IFTEST_OK    = 8'h00;

    localparam int CB_KBD_IE   = 0;
    localparam int CB_AUX_IE   = 1;
    localparam int CB_IGN_LOCK = 3;
    localparam int CB_KBD_OFF  = 4;
    localparam int CB_AUX_OFF  = 5;

    localparam int NUM_PORTS = 2;
    localparam int PORT_KBD  = 0;
    localparam int PORT_AUX  = 1;

    typedef enum logic [2:0] {
        PEND_NONE, PEND_CTRL, PEND_AUX_SEND, PEND_KBD_ECHO, PEND_AUX_ECHO
    } pend_t;

    typedef enum logic {SRC_KBD = 1'b0, SRC_AUX = 1'b1} src_t;
endpackage

// File: rtl/kbc_host_if.sv
// Host write capture: latches one accepted byte plus its command/data flag
// and holds input-full for exactly one cycle, the execute cycle.
// Assumes the host respects input-full; writes while it is set are dropped.
module kbc_host_if
    import kbc_pkg::*;
#(
    parameter int ADDR_W      = 3,
    parameter int DATA_OFFSET = 0,
    parameter int CMD_OFFSET  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [ADDR_W-1:0] host_addr,
    input  kbyte_t            host_wdata,
    output logic              ibf,
    output logic              cmd_flag,
    output kbyte_t            in_byte
);
    localparam logic [ADDR_W-1:0] CMD_A = CMD_OFFSET[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A = DATA_OFFSET[ADDR_W-1:0];

    logic hit_cmd, hit_dat, accept;
    assign hit_cmd = (host_addr == CMD_A);
    assign hit_dat = (host_addr == DAT_A);
    assign accept  = host_wr && !ibf && (hit_cmd || hit_dat);

    // Capture an accepted write; input-full drops after the execute cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ibf      <= 1'b0;
            cmd_flag <= 1'b0;
            in_byte  <= '0;
        end else if (accept) begin
            ibf      <= 1'b1;
            cmd_flag <= hit_cmd;
            in_byte  <= host_wdata;
        end else begin
            ibf      <= 1'b0;
        end
    end
endmodule

// File: rtl/kbc_cmd_engine.sv
// Command engine: decodes the captured host byte during the execute cycle.
// It updates the control register and the armed parameter phase, emits
// controller results to the output buffer, and forwards bytes to devices.
// Assumes exec is high for exactly one cycle per accepted host write.
module kbc_cmd_engine
    import kbc_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RESET_CTRL = 8'h00
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   exec,
    input  logic   is_cmd,
    input  kbyte_t in_byte,
    output kbyte_t ctrl,
    output logic   res_load,
    output kbyte_t res_byte,
    output src_t   res_src,
    output logic   kbd_out_valid,
    output kbyte_t kbd_out_data,
    output logic   aux_out_valid,
    output kbyte_t aux_out_data
);
    pend_t pend;
    logic  do_cmd, do_dat;
    assign do_cmd = exec && is_cmd;
    assign do_dat = exec && !is_cmd;

    // Result bytes for the output buffer, produced in the execute cycle.
    always_comb begin
        res_load = 1'b0;
        res_byte = '0;
        res_src  = SRC_KBD;
        if (do_cmd) begin
            case (in_byte)
                OP_RD_CTRL:               begin res_load = 1'b1; res_byte = ctrl;        end
                OP_SELFTEST:              begin res_load = 1'b1; res_byte = SELFTEST_OK; end
                OP_KBD_TEST, OP_AUX_TEST: begin res_load = 1'b1; res_byte = IFTEST_OK;   end
                default: ;
            endcase
        end else if (do_dat) begin
            case (pend)
                PEND_KBD_ECHO: begin res_load = 1'b1; res_byte = in_byte; end
                PEND_AUX_ECHO: begin res_load = 1'b1; res_byte = in_byte; res_src = SRC_AUX; end
                default: ;
            endcase
        end
    end

    // Control register and parameter phase; unknown opcodes touch neither.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= RESET_CTRL;
            pend <= PEND_NONE;
        end else if (do_cmd) begin
            case (in_byte)
                OP_WR_CTRL:  pend <= PEND_CTRL;
                OP_AUX_SEND: pend <= PEND_AUX_SEND;
                OP_KBD_ECHO: pend <= PEND_KBD_ECHO;
                OP_AUX_ECHO: pend <= PEND_AUX_ECHO;
                OP_AUX_OFF:  begin ctrl[CB_AUX_OFF] <= 1'b1; pend <= PEND_NONE; end
                OP_AUX_ON:   begin ctrl[CB_AUX_OFF] <= 1'b0; pend <= PEND_NONE; end
                OP_KBD_OFF:  begin ctrl[CB_KBD_OFF] <= 1'b1; pend <= PEND_NONE; end
                OP_KBD_ON:   begin ctrl[CB_KBD_OFF] <= 1'b0; pend <= PEND_NONE; end
                OP_RD_CTRL, OP_SELFTEST, OP_KBD_TEST, OP_AUX_TEST: pend <= PEND_NONE;
                default: ;
            endcase
        end else if (do_dat) begin
            if (pend == PEND_CTRL) ctrl <= in_byte;
            pend <= PEND_NONE;
        end
    end

    // Device forward strobes, one cycle each.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kbd_out_valid <= 1'b0;
            aux_out_valid <= 1'b0;
            kbd_out_data  <= '0;
            aux_out_data  <= '0;
        end else begin
            kbd_out_valid <= do_dat && (pend == PEND_NONE);
            aux_out_valid <= do_dat && (pend == PEND_AUX_SEND);
            if (do_dat && pend == PEND_NONE)     kbd_out_data <= in_byte;
            if (do_dat && pend == PEND_AUX_SEND) aux_out_data <= in_byte;
        end
    end
endmodule

// File: rtl/kbc_out_buf.sv
// Output buffer: one byte plus source tag and full flag. Controller results
// overwrite; device bytes enter only when empty and their port is on, with
// the lower port index winning. A host data read empties it.
// Assumes port 0 is the keyboard and port 1 the pointer.
module kbc_out_buf
    import kbc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 res_load,
    input  kbyte_t               res_byte,
    input  src_t                 res_src,
    input  logic [NUM_PORTS-1:0] dev_valid,
    input  kbyte_t [NUM_PORTS-1:0] dev_data,
    input  logic [NUM_PORTS-1:0] port_off,
    input  logic                 rd_take,
    output logic                 obf,
    output kbyte_t               obuf,
    output src_t                 src
);
    logic [NUM_PORTS-1:0] elig;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_elig
        assign elig[p] = dev_valid[p] && !port_off[p];
    end

    // Load priority: controller result, keyboard, pointer, then read drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            obf  <= 1'b0;
            obuf <= '0;
            src  <= SRC_KBD;
        end else if (res_load) begin
            obf  <= 1'b1;
            obuf <= res_byte;
            src  <= res_src;
        end else if (!obf && elig[PORT_KBD]) begin
            obf  <= 1'b1;
            obuf <= dev_data[PORT_KBD];
            src  <= SRC_KBD;
        end else if (!obf && elig[PORT_AUX]) begin
            obf  <= 1'b1;
            obuf <= dev_data[PORT_AUX];
            src  <= SRC_AUX;
        end else if (rd_take) begin
            obf  <= 1'b0;
        end
    end
endmodule

// File: rtl/kbc_dual_port.sv
// Top: host-visible register model of a dual-port keyboard/pointer
// controller. Wires the write capture, command engine and output buffer
// together and forms the status byte, read mux and interrupt outputs.
// Assumes one host access per cycle and byte-wide device strobes.
module kbc_dual_port
    import kbc_pkg::*;
#(
    parameter int                ADDR_W      = 3,
    parameter int                DATA_OFFSET = 0,
    parameter int                CMD_OFFSET  = 4,
    parameter logic [BYTE_W-1:0] RESET_CTRL  = 8'h00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    input  logic              lock_open,
    input  logic              kbd_in_valid,
    input  logic [7:0]        kbd_in_data,
    input  logic              aux_in_valid,
    input  logic [7:0]        aux_in_data,
    output logic              kbd_out_valid,
    output logic [7:0]        kbd_out_data,
    output logic              aux_out_valid,
    output logic [7:0]        aux_out_data,
    output logic              kbd_irq,
    output logic              aux_irq
);
    localparam logic [ADDR_W-1:0] CMD_A = CMD_OFFSET[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A = DATA_OFFSET[ADDR_W-1:0];

    logic   ibf, cmd_flag, obf, res_load, rd_take;
    kbyte_t in_byte, ctrl, res_byte, obuf, status;
    src_t   res_src, src;

    kbc_host_if #(.ADDR_W(ADDR_W), .DATA_OFFSET(DATA_OFFSET), .CMD_OFFSET(CMD_OFFSET)) u_host (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .ibf(ibf), .cmd_flag(cmd_flag), .in_byte(in_byte)
    );

    kbc_cmd_engine #(.RESET_CTRL(RESET_CTRL)) u_cmd (
        .clk(clk), .rst_n(rst_n), .exec(ibf), .is_cmd(cmd_flag), .in_byte(in_byte),
        .ctrl(ctrl), .res_load(res_load), .res_byte(res_byte), .res_src(res_src),
        .kbd_out_valid(kbd_out_valid), .kbd_out_data(kbd_out_data),
        .aux_out_valid(aux_out_valid), .aux_out_data(aux_out_data)
    );

    assign rd_take = host_rd && (host_addr == DAT_A);

    kbc_out_buf u_obuf (
        .clk(clk), .rst_n(rst_n), .res_load(res_load), .res_byte(res_byte), .res_src(res_src),
        .dev_valid({aux_in_valid, kbd_in_valid}), .dev_data({aux_in_data, kbd_in_data}),
        .port_off({ctrl[CB_AUX_OFF], ctrl[CB_KBD_OFF]}), .rd_take(rd_take),
        .obf(obf), .obuf(obuf), .src(src)
    );

    // Status byte: parity, timeout, source, lock, cmd/data, 0, in-full, out-full.
    assign status = {2'b00, (src == SRC_AUX), (lock_open || ctrl[CB_IGN_LOCK]),
                     cmd_flag, 1'b0, ibf, obf};

    // Read mux: the command offset reads status, the data offset the buffer.
    assign host_rdata = (host_addr == CMD_A) ? status : obuf;

    // Per-port interrupt requests gated by the control register enables.
    assign kbd_irq = obf && (src == SRC_KBD) && ctrl[CB_KBD_IE];
    assign aux_irq = obf && (src == SRC_AUX) && ctrl[CB_AUX_IE];
endmodule

// File: rtl/kbc_dual_port_chk.sv
// Assertion checker for kbc_dual_port, attached by bind below.
// Assumes rst_n is held low from time zero until the first clock edges.
module kbc_dual_port_chk #(
    parameter int ADDR_W      = 3,
    parameter int DATA_OFFSET = 0,
    parameter int CMD_OFFSET  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic              host_rd,
    input logic              ibf,
    input logic              obf,
    input logic [7:0]        obuf,
    input logic [7:0]        ctrl,
    input logic              kbd_irq,
    input logic              aux_irq,
    input logic              kbd_out_valid,
    input logic              aux_out_valid
);
    localparam logic [ADDR_W-1:0] CMD_A = CMD_OFFSET[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] DAT_A = DATA_OFFSET[ADDR_W-1:0];

    AST_IBF_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) ibf |=> !ibf); // R2
    AST_WRITE_RAISES_IBF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && !ibf && (host_addr == CMD_A || host_addr == DAT_A)) |=> ibf); // R2
    AST_READ_DRAINS_OBF: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == DAT_A && obf && !ibf) |=> !obf); // R4
    AST_CTRL_ONLY_ON_EXEC: assert property (@(posedge clk) disable iff (!rst_n) !ibf |=> $stable(ctrl)); // R5
    AST_FWD_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_out_valid || aux_out_valid) |-> $past(ibf)); // R9
    AST_FWD_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_out_valid, aux_out_valid})); // R9
    AST_HELD_BYTE_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (obf && !ibf) |=> $stable(obuf)); // R10
    AST_BOTH_OFF_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!obf && !ibf && ctrl[4] && ctrl[5]) |=> !obf); // R10
    AST_IRQ_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (kbd_irq || aux_irq) |-> obf); // R11
    AST_IRQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kbd_irq, aux_irq})); // R11
endmodule

bind kbc_dual_port kbc_dual_port_chk #(
    .ADDR_W(ADDR_W), .DATA_OFFSET(DATA_OFFSET), .CMD_OFFSET(CMD_OFFSET)
) u_chk (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .ibf(ibf), .obf(obf), .obuf(obuf), .ctrl(ctrl), .kbd_irq(kbd_irq), .aux_irq(aux_irq),
    .kbd_out_valid(kbd_out_valid), .aux_out_valid(aux_out_valid)
);

// File: tb/kbc_dual_port_bench.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of host operations, then directed
// tests for reset, input-full timing, forwarding, device loads and keylock.
module kbc_dual_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] host_addr = '0;
    logic       host_wr = 1'b0, host_rd = 1'b0;
    logic [7:0] host_wdata = '0, host_rdata;
    logic       lock_open = 1'b1;
    logic       kbd_in_valid = 1'b0, aux_in_valid = 1'b0;
    logic [7:0] kbd_in_data = '0, aux_in_data = '0;
    logic       kbd_out_valid, aux_out_valid, kbd_irq, aux_irq;
    logic [7:0] kbd_out_data, aux_out_data;

    int total = 0, bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    kbc_dual_port u_kbc_dual_port (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .lock_open(lock_open),
        .kbd_in_valid(kbd_in_valid), .kbd_in_data(kbd_in_data),
        .aux_in_valid(aux_in_valid), .aux_in_data(aux_in_data),
        .kbd_out_valid(kbd_out_valid), .kbd_out_data(kbd_out_data),
        .aux_out_valid(aux_out_valid), .aux_out_data(aux_out_data),
        .kbd_irq(kbd_irq), .aux_irq(aux_irq)
    );

    localparam logic [2:0] A_DAT = 3'd0, A_CMD = 3'd4;
    localparam logic [1:0] K_WCMD = 2'd0, K_WDAT = 2'd1, K_RDAT = 2'd2, K_RSTA = 2'd3;
    localparam int NV = 35;
    // {kind, requirement number, value written, value expected}
    localparam logic [21:0] VEC [NV] = '{
        {K_WCMD, 4'd6,  8'hAA, 8'h00},
        {K_RSTA, 4'd3,  8'h00, 8'h19},  // R3 cmd flag, R6 result waiting
        {K_RDAT, 4'd6,  8'h00, 8'h55},  // R6 self-test
        {K_RSTA, 4'd4,  8'h00, 8'h18},  // R4 read drained
        {K_WCMD, 4'd6,  8'hAB, 8'h00},
        {K_RDAT, 4'd6,  8'h00, 8'h00},  // R6 kbd test
        {K_WCMD, 4'd6,  8'hA9, 8'h00},
        {K_RDAT, 4'd6,  8'h00, 8'h00},  // R6 aux test
        {K_WCMD, 4'd5,  8'h60, 8'h00},
        {K_WDAT, 4'd5,  8'h43, 8'h00},
        {K_RSTA, 4'd3,  8'h00, 8'h10},  // R3 data write clears flag
        {K_WCMD, 4'd5,  8'h20, 8'h00},
        {K_RDAT, 4'd5,  8'h00, 8'h43},  // R5 control readback
        {K_WCMD, 4'd7,  8'hA7, 8'h00},
        {K_WCMD, 4'd7,  8'h20, 8'h00},
        {K_RDAT, 4'd7,  8'h00, 8'h63},  // R7 aux off
        {K_WCMD, 4'd7,  8'hAD, 8'h00},
        {K_WCMD, 4'd7,  8'h20, 8'h00},
        {K_RDAT, 4'd7,  8'h00, 8'h73},  // R7 kbd off
        {K_WCMD, 4'd7,  8'hA8, 8'h00},
        {K_WCMD, 4'd7,  8'hAE, 8'h00},
        {K_WCMD, 4'd7,  8'h20, 8'h00},
        {K_RDAT, 4'd7,  8'h00, 8'h43},  // R7 both back on
        {K_WCMD, 4'd8,  8'hD3, 8'h00},
        {K_WDAT, 4'd8,  8'h5A, 8'h00},
        {K_RSTA, 4'd8,  8'h00, 8'h31},  // R8 aux tag set
        {K_RDAT, 4'd8,  8'h00, 8'h5A},
        {K_WCMD, 4'd8,  8'hD2, 8'h00},
        {K_WDAT, 4'd8,  8'h3C, 8'h00},
        {K_RSTA, 4'd8,  8'h00, 8'h11},  // R8 kbd tag
        {K_RDAT, 4'd8,  8'h00, 8'h3C},
        {K_WCMD, 4'd12, 8'h11, 8'h00},
        {K_RSTA, 4'd12, 8'h00, 8'h18},  // R12 no result produced
        {K_WCMD, 4'd12, 8'h20, 8'h00},
        {K_RDAT, 4'd12, 8'h00, 8'h43}   // R12 control untouched
    };

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
        @(negedge clk); host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk); host_addr = a; host_rd = 1'b1;
        #1 v = host_rdata;
        @(negedge clk); host_rd = 1'b0;
    endtask

    task automatic peek_status(output logic [7:0] v);
        host_addr = A_CMD;
        #1 v = host_rdata;
    endtask

    task automatic dev_push(input logic kv, input logic [7:0] kd, input logic av, input logic [7:0] ad);
        @(negedge clk); kbd_in_valid = kv; kbd_in_data = kd; aux_in_valid = av; aux_in_data = ad;
        @(negedge clk); kbd_in_valid = 1'b0; aux_in_valid = 1'b0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        peek_status(v); chk("R1 status", v, 8'h10);
        chk("R1 irqs", {6'd0, kbd_irq, aux_irq}, 8'h00);
        chk("R1 strobes", {6'd0, kbd_out_valid, aux_out_valid}, 8'h00);
        host_write(A_CMD, 8'h20); host_read(A_DAT, v); chk("R1 ctrl", v, 8'h00);

        // R2 input-full lasts one cycle; a write during it is dropped
        @(negedge clk); host_addr = A_CMD; host_wdata = 8'hAA; host_wr = 1'b1;
        @(negedge clk); host_wdata = 8'h20;
        #1 chk("R2 ibf set", host_rdata & 8'h02, 8'h02);
        @(negedge clk); host_wr = 1'b0;
        #1 chk("R2 ibf clear", host_rdata & 8'h02, 8'h00);
        host_read(A_DAT, v); chk("R2 second write ignored", v, 8'h55);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            logic [1:0] k;
            string      tag;
            k   = VEC[i][21:20];
            tag = $sformatf("R%0d row %0d", VEC[i][19:16], i);
            case (k)
                K_WCMD: host_write(A_CMD, VEC[i][15:8]);
                K_WDAT: host_write(A_DAT, VEC[i][15:8]);
                K_RDAT: begin host_read(A_DAT, v); chk(tag, v, VEC[i][7:0]); end
                default: begin @(negedge clk); peek_status(v); chk(tag, v, VEC[i][7:0]); end
            endcase
        end

        // R9 forwarding strobes
        host_write(A_DAT, 8'h77);
        chk("R9 kbd strobe", {7'd0, kbd_out_valid}, 8'h01);
        chk("R9 kbd byte", kbd_out_data, 8'h77);
        chk("R9 aux quiet", {7'd0, aux_out_valid}, 8'h00);
        @(negedge clk); chk("R9 kbd pulse ends", {7'd0, kbd_out_valid}, 8'h00);
        host_write(A_CMD, 8'hD4); host_write(A_DAT, 8'h99);
        chk("R9 aux strobe", {7'd0, aux_out_valid}, 8'h01);
        chk("R9 aux byte", aux_out_data, 8'h99);
        chk("R9 kbd quiet", {7'd0, kbd_out_valid}, 8'h00);

        // R10/R11 device loads with ctrl = 0x43
        dev_push(1'b1, 8'hA1, 1'b0, 8'h00);
        peek_status(v); chk("R10 kbd loaded", v, 8'h11);
        chk("R11 kbd irq", {6'd0, kbd_irq, aux_irq}, 8'h02);
        dev_push(1'b0, 8'h00, 1'b1, 8'hB2);
        host_read(A_DAT, v); chk("R10 held byte kept", v, 8'hA1);
        dev_push(1'b0, 8'h00, 1'b1, 8'hB2);
        peek_status(v); chk("R10 aux loaded tagged", v, 8'h31);
        chk("R11 aux irq", {6'd0, kbd_irq, aux_irq}, 8'h01);
        host_read(A_DAT, v); chk("R10 aux byte", v, 8'hB2);
        dev_push(1'b1, 8'hD1, 1'b1, 8'hE2);
        host_read(A_DAT, v); chk("R10 kbd priority", v, 8'hD1);
        host_write(A_CMD, 8'hAD);
        dev_push(1'b1, 8'hC7, 1'b0, 8'h00);
        peek_status(v); chk("R10 disabled port blocked", v & 8'h01, 8'h00);
        host_write(A_CMD, 8'hAE);

        // R11 interrupt masked by enable bit
        host_write(A_CMD, 8'h60); host_write(A_DAT, 8'h40);
        dev_push(1'b1, 8'hC3, 1'b0, 8'h00);
        peek_status(v); chk("R11 byte waiting", v & 8'h01, 8'h01);
        chk("R11 irq masked", {6'd0, kbd_irq, aux_irq}, 8'h00);
        host_read(A_DAT, v);

        // R13 keylock and reserved status bits
        lock_open = 1'b0;
        @(negedge clk); peek_status(v);
        chk("R13 locked", v & 8'h10, 8'h00);
        chk("R13 reserved bits", v & 8'hC4, 8'h00);
        host_write(A_CMD, 8'h60); host_write(A_DAT, 8'h48);
        peek_status(v); chk("R13 ignore lock", v & 8'h10, 8'h10);

        finish_run();
    end
endmodule